// File: doc/BRIEF.md
# Prescaled Free-Running Timer

This block is a 16-bit up counter that advances on ticks from a programmable power-of-two prescaler. A byte-wide register bus reads the count and programs a control register and a divide select. Control bits switch the timer on and off, stop it while the system sits in a low-power wait state, and hold it while a debug freeze is requested. A precision flag may be set once after reset and is then fixed.

The prescaler also drives a tick that fires once every 64 running cycles, whatever the divide select is. An external pulse accumulator uses it. A stop indication tells that accumulator and a modulus counter to halt during wait. The counter can be loaded only in a test mode. A load does not realign the prescaler, so the first period after a load may be short. On wrap the block gives a one-cycle overflow pulse.

Top module: `freerun_timer`

## Requirements
- R1: After reset the count is 0x0000, the control register and the divide select read 0x00, read data is 0x00 and no output pulse is active.
- R2: While running, the count increases by one on each prescaler tick. A tick occurs every 2^S running cycles, where S is bits 2:0 of the divide-select register at address 3.
- R3: A read strobe loads read data at the next clock edge with the value as of the strobe cycle. Address 0 gives count bits 15:8, address 1 gives bits 7:0, address 2 gives the control byte and address 3 gives the divide select. Without a strobe the read data holds.
- R4: The count wraps from 0xFFFF to 0x0000, and overflow_o is high for exactly the one cycle in which the count first shows 0x0000.
- R5: A write to address 0 (high byte) or address 1 (low byte) loads the count only while test_mode_i is high. Otherwise the write is ignored.
- R6: A count load does not reset the prescaler. The next increment after a load comes at the prescaler's running phase.
- R7: Control byte layout: bit 7 enable, bit 6 stop-in-wait, bit 5 freeze-enable, bit 4 fast-clear flag (stored only), bit 3 precision flag. Bits 2:0 always read 0.
- R8: With enable clear, the count, the prescaler and div64_tick_o all stop.
- R9: With stop-in-wait set and wait_i high, the count and prescaler halt and acc_stop_o is high. With stop-in-wait clear, wait_i has no effect.
- R10: The first control write after reset sets the precision flag. Later writes leave it unchanged, while bits 7:4 stay writable.
- R11: With freeze-enable set and freeze_i high, the count and prescaler hold.
- R12: div64_tick_o pulses once every 64 running cycles, independent of the divide select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| test_mode_i | input | 1 | Test mode; allows count loads |
| wait_i | input | 1 | System wait state |
| freeze_i | input | 1 | Debug freeze request |
| bus_addr_i | input | 2 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| count_o | output | 16 | Current count |
| overflow_o | output | 1 | One-cycle wrap pulse |
| div64_tick_o | output | 1 | Divide-by-64 tick for a pulse accumulator |
| acc_stop_o | output | 1 | Stop indication during wait |

## Verification
Count, prescaler phase, the overflow pulse and read data are registered. Each is due at the first falling edge after the rising edge that consumed the stimulus. div64_tick_o and acc_stop_o are combinational from state and the wait and freeze inputs, so they are due in the same cycle. The bench drives inputs just after a falling edge and compares every output with a behavioural model at the following falling edge. The directed checks count cycles from a known prescaler phase: for example, the fifth cycle after a load at phase 2 of a divide-by-8.

// File: rtl/freerun_timer_pkg.sv
// Package for the prescaled free-running timer: register addresses,
// control register type and the control byte packing helper.
package freerun_timer_pkg;

    localparam logic [1:0] ADDR_CNT_HI = 2'd0;
    localparam logic [1:0] ADDR_CNT_LO = 2'd1;
    localparam logic [1:0] ADDR_CTRL   = 2'd2;
    localparam logic [1:0] ADDR_DIVSEL = 2'd3;

    typedef struct packed {
        logic run_en;     // byte bit 7
        logic wait_stop;  // byte bit 6
        logic frz_en;     // byte bit 5
        logic fast_clr;   // byte bit 4
        logic precise;    // byte bit 3
    } tmr_ctrl_t;

    // Pack control fields into the readable byte; low three bits read zero.
    function automatic logic [7:0] ctrl_to_byte(tmr_ctrl_t c);
        return {c.run_en, c.wait_stop, c.frz_en, c.fast_clr, c.precise, 3'b000};
    endfunction

endpackage

// File: rtl/ft_prescaler.sv
// Free-running power-of-two prescaler.
// Assumes: SEL_W select bits choose a divide of 2^sel; the phase counter is
// 2^SEL_W-1 bits wide so every divide and the accumulator tick share one phase.
// Ticks are combinational from the phase and run_i.
module ft_prescaler #(
    parameter int SEL_W    = 3,
    parameter int ACC_LOG2 = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o,
    output logic             acc_tick_o
);
    localparam int PRE_W = (1 << SEL_W) - 1;

    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] sel_mask;

    // Advance the phase on every running cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (run_i)
            phase_q <= phase_q + 1'b1;
    end

    // Mask of the low phase bits that must all be one for a tick.
    always_comb begin
        sel_mask = ~({PRE_W{1'b1}} << sel_i);
    end

    // Tick outputs.
    always_comb begin
        tick_o     = run_i && ((phase_q & sel_mask) == sel_mask);
        acc_tick_o = run_i && (&phase_q[ACC_LOG2-1:0]);
    end

endmodule

// File: rtl/ft_counter.sv
// Main up counter with byte loads and a registered wrap pulse.
// Assumes: CNT_W is 9..16 so the high byte load covers bits CNT_W-1:8;
// a load wins over an increment in the same cycle.
module ft_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             ld_hi_i,
    input  logic             ld_lo_i,
    input  logic [7:0]       ld_data_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);
    localparam int HI_W = CNT_W - 8;

    logic [CNT_W-1:0] cnt_q;
    logic             wrap_q;

    // Load or increment the count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (ld_hi_i)
            cnt_q[CNT_W-1:8] <= ld_data_i[HI_W-1:0];
        else if (ld_lo_i)
            cnt_q[7:0] <= ld_data_i;
        else if (tick_i)
            cnt_q <= cnt_q + 1'b1;
    end

    // Flag the cycle in which the count has just wrapped to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wrap_q <= 1'b0;
        else
            wrap_q <= tick_i && !ld_hi_i && !ld_lo_i && (&cnt_q);
    end

    assign count_o = cnt_q;
    assign wrap_o  = wrap_q;

endmodule

// File: rtl/ft_regs.sv
// Control and divide-select registers.
// Assumes: any control write locks the precision flag after applying it
// once; the divide select is writable at any time.
module ft_regs
    import freerun_timer_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl_i,
    input  logic             wr_sel_i,
    input  logic [7:0]       wdata_i,
    output tmr_ctrl_t        ctrl_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             lock_o
);
    tmr_ctrl_t        ctrl_q;
    logic             lock_q;
    logic [SEL_W-1:0] sel_q;

    // Control fields; the precision flag only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            lock_q <= 1'b0;
        end else if (wr_ctrl_i) begin
            ctrl_q.run_en    <= wdata_i[7];
            ctrl_q.wait_stop <= wdata_i[6];
            ctrl_q.frz_en    <= wdata_i[5];
            ctrl_q.fast_clr  <= wdata_i[4];
            if (!lock_q)
                ctrl_q.precise <= wdata_i[3];
            lock_q <= 1'b1;
        end
    end

    // Divide select.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (wr_sel_i)
            sel_q <= wdata_i[SEL_W-1:0];
    end

    assign ctrl_o = ctrl_q;
    assign sel_o  = sel_q;
    assign lock_o = lock_q;

    if (SEL_W < 8) begin : g_sel_unused
        logic unused_hi;
        assign unused_hi = ^wdata_i[7:SEL_W];
    end

endmodule

// File: rtl/freerun_timer.sv
// Top of the prescaled free-running timer: bus decode, run gating,
// registered read mux, and the exported accumulator tick and stop.
// Assumes: CNT_W in 9..16, SEL_W <= 3 so the select fits the low byte bits.
module freerun_timer
    import freerun_timer_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int SEL_W    = 3,
    parameter int ACC_LOG2 = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             test_mode_i,
    input  logic             wait_i,
    input  logic             freeze_i,
    input  logic [1:0]       bus_addr_i,
    input  logic             bus_wr_i,
    input  logic             bus_rd_i,
    input  logic [7:0]       bus_wdata_i,
    output logic [7:0]       bus_rdata_o,
    output logic [CNT_W-1:0] count_o,
    output logic             overflow_o,
    output logic             div64_tick_o,
    output logic             acc_stop_o
);
    tmr_ctrl_t        ctrl;
    logic [SEL_W-1:0] div_sel;
    logic             lock_w;
    logic             precise_w;
    logic             run_w;
    logic             pre_tick_w;
    logic             ld_hi, ld_lo, cnt_wr_w;
    logic             wr_ctrl, wr_sel;
    logic [7:0]       rd_mux;
    logic [7:0]       rdata_q;

    // Decode bus writes; count loads need test mode.
    always_comb begin
        ld_hi    = bus_wr_i && test_mode_i && (bus_addr_i == ADDR_CNT_HI);
        ld_lo    = bus_wr_i && test_mode_i && (bus_addr_i == ADDR_CNT_LO);
        cnt_wr_w = ld_hi || ld_lo;
        wr_ctrl  = bus_wr_i && (bus_addr_i == ADDR_CTRL);
        wr_sel   = bus_wr_i && (bus_addr_i == ADDR_DIVSEL);
    end

    // Timer runs when enabled and not stopped by wait or freeze.
    always_comb begin
        acc_stop_o = ctrl.wait_stop && wait_i;
        run_w      = ctrl.run_en && !acc_stop_o && !(ctrl.frz_en && freeze_i);
    end

    ft_regs #(.SEL_W(SEL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl_i (wr_ctrl),
        .wr_sel_i  (wr_sel),
        .wdata_i   (bus_wdata_i),
        .ctrl_o    (ctrl),
        .sel_o     (div_sel),
        .lock_o    (lock_w)
    );

    ft_prescaler #(.SEL_W(SEL_W), .ACC_LOG2(ACC_LOG2)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run_w),
        .sel_i      (div_sel),
        .tick_o     (pre_tick_w),
        .acc_tick_o (div64_tick_o)
    );

    ft_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (pre_tick_w),
        .ld_hi_i   (ld_hi),
        .ld_lo_i   (ld_lo),
        .ld_data_i (bus_wdata_i),
        .count_o   (count_o),
        .wrap_o    (overflow_o)
    );

    assign precise_w = ctrl.precise;

    // Select the byte addressed by the bus.
    always_comb begin
        unique case (bus_addr_i)
            ADDR_CNT_HI: rd_mux = 8'(count_o >> 8);
            ADDR_CNT_LO: rd_mux = count_o[7:0];
            ADDR_CTRL:   rd_mux = ctrl_to_byte(ctrl);
            default:     rd_mux = 8'(div_sel);
        endcase
    end

    // Register read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (bus_rd_i)
            rdata_q <= rd_mux;
    end

    assign bus_rdata_o = rdata_q;

endmodule

// File: rtl/freerun_timer_chk.sv
// Assertion checker for freerun_timer, attached by bind.
module freerun_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] count_o,
    input logic             overflow_o,
    input logic             div64_tick_o,
    input logic             acc_stop_o,
    input logic             run_w,
    input logic             pre_tick_w,
    input logic             cnt_wr_w,
    input logic             precise_w,
    input logic             lock_w
);
    // R2: a tick without a load steps the count by one
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_tick_w && !cnt_wr_w) |=> (count_o == $past(count_o) + 1'b1));

    // R4: overflow pulse only while the count shows zero
    a_r4_ovf_zero: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> (count_o == '0));

    // R8: a halted timer keeps its count
    a_r8_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_w && !cnt_wr_w) |=> $stable(count_o));

    // R9: stop indication means the timer is not running
    a_r9_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
        acc_stop_o |-> !run_w);

    // R10: once locked, the precision flag never changes
    a_r10_lock: assert property (@(posedge clk) disable iff (!rst_n)
        lock_w |=> $stable(precise_w));

    // R12: accumulator tick only while running
    a_r12_tick_run: assert property (@(posedge clk) disable iff (!rst_n)
        div64_tick_o |-> run_w);

endmodule

bind freerun_timer freerun_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .count_o      (count_o),
    .overflow_o   (overflow_o),
    .div64_tick_o (div64_tick_o),
    .acc_stop_o   (acc_stop_o),
    .run_w        (run_w),
    .pre_tick_w   (pre_tick_w),
    .cnt_wr_w     (cnt_wr_w),
    .precise_w    (precise_w),
    .lock_w       (lock_w)
);

// File: tb/freerun_timer_tb.sv
module freerun_timer_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        test_mode = 1'b0, wait_in = 1'b0, freeze_in = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic [15:0] count;
    logic        ovf, div64, acc_stop;

    int checks = 0, errors = 0, div64_seen = 0;
    bit ovf_zero_seen = 0;

    // behavioural model state
    int m_cnt = 0, m_pre = 0, m_rdata = 0, m_sel = 0;
    bit m_ovf = 0, m_en = 0, m_sw = 0, m_frz = 0, m_ffc = 0, m_pr = 0, m_lock = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    freerun_timer u_dut (
        .clk(clk), .rst_n(rst_n), .test_mode_i(test_mode), .wait_i(wait_in),
        .freeze_i(freeze_in), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .count_o(count),
        .overflow_o(ovf), .div64_tick_o(div64), .acc_stop_o(acc_stop)
    );

    function automatic int ctrl_byte();
        return (int'(m_en) << 7) | (int'(m_sw) << 6) | (int'(m_frz) << 5)
             | (int'(m_ffc) << 4) | (int'(m_pr) << 3);
    endfunction

    function automatic bit m_run();
        return m_en && !(m_sw && wait_in) && !(m_frz && freeze_in);
    endfunction

    // reference model, one step per rising edge
    always @(posedge clk) begin
        int per;
        bit run, tick;
        if (!rst_n) begin
            m_cnt = 0; m_pre = 0; m_rdata = 0; m_sel = 0; m_ovf = 0;
            m_en = 0; m_sw = 0; m_frz = 0; m_ffc = 0; m_pr = 0; m_lock = 0;
        end else begin
            run  = m_run();
            per  = 1 << m_sel;
            tick = run && ((m_pre % per) == per - 1);
            if (rd) begin
                case (addr)
                    2'd0: m_rdata = m_cnt / 256;
                    2'd1: m_rdata = m_cnt % 256;
                    2'd2: m_rdata = ctrl_byte();
                    default: m_rdata = m_sel;
                endcase
            end
            m_ovf = 0;
            if (wr && test_mode && addr == 2'd0)
                m_cnt = int'(wdata) * 256 + (m_cnt % 256);
            else if (wr && test_mode && addr == 2'd1)
                m_cnt = (m_cnt / 256) * 256 + int'(wdata);
            else if (tick) begin
                if (m_cnt == 65535) begin m_cnt = 0; m_ovf = 1; end
                else m_cnt = m_cnt + 1;
            end
            if (run) m_pre = (m_pre + 1) % 128;
            if (wr && addr == 2'd2) begin
                m_en = wdata[7]; m_sw = wdata[6]; m_frz = wdata[5]; m_ffc = wdata[4];
                if (!m_lock) m_pr = wdata[3];
                m_lock = 1;
            end
            if (wr && addr == 2'd3) m_sel = int'(wdata[2:0]);
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare all outputs with the model
    task automatic compare_all();
        check("R2", "count", int'(count), m_cnt);
        check("R4", "overflow", int'(ovf), int'(m_ovf));
        check("R3", "rdata", int'(rdata), m_rdata);
        check("R12", "div64", int'(div64), int'(m_run() && (m_pre % 64 == 63)));
        check("R9", "acc_stop", int'(acc_stop), int'(m_sw && wait_in));
        if (div64) div64_seen++;
        if (ovf && count == 16'h0000) ovf_zero_seen = 1;
    endtask

    task automatic cyc();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic bus_write(logic [1:0] a, logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        cyc();
        wr = 1'b0;
    endtask

    task automatic bus_read(logic [1:0] a, output logic [7:0] d);
        addr = a; rd = 1'b1;
        cyc();
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] rb;
        logic [15:0] snap;
        int steps;

        do_reset();
        // R1 reset state
        check("R1", "count after reset", int'(count), 0);
        check("R1", "overflow after reset", int'(ovf), 0);
        bus_read(2'd2, rb); check("R1", "ctrl after reset", int'(rb), 8'h00);
        bus_read(2'd3, rb); check("R1", "divsel after reset", int'(rb), 8'h00);

        // R8 disabled: nothing moves
        snap = count; div64_seen = 0;
        idle(80);
        check("R8", "count while disabled", int'(count), int'(snap));
        check("R8", "div64 pulses while disabled", div64_seen, 0);

        // R5 normal-mode count write ignored
        bus_write(2'd1, 8'h5A);
        bus_write(2'd0, 8'hA5);
        check("R5", "count after normal write", int'(count), 0);

        // R3 read back after a test-mode load
        test_mode = 1'b1;
        bus_write(2'd0, 8'h12);
        bus_write(2'd1, 8'h34);
        test_mode = 1'b0;
        bus_read(2'd0, rb); check("R3", "count high byte", int'(rb), 8'h12);
        bus_read(2'd1, rb); check("R3", "count low byte", int'(rb), 8'h34);
        idle(2);
        check("R3", "rdata holds without strobe", int'(rdata), 8'h34);

        // R2 enable with divide-by-4: 40 cycles give 10 steps
        bus_write(2'd3, 8'h02);
        bus_write(2'd2, 8'h80);   // first control write locks precise at 0
        snap = count;
        idle(40);
        check("R2", "steps in 40 cycles at div4", int'(count - snap), 10);

        // R12 divide-by-32 select; 128 running cycles give 2 div64 pulses
        bus_write(2'd3, 8'h05);
        div64_seen = 0;
        idle(128);
        check("R12", "div64 pulses in 128 cycles", div64_seen, 2);

        // R6 load mid-phase at div8
        bus_write(2'd3, 8'h03);
        snap = count;
        for (int i = 0; i < 20 && count == snap; i++) cyc();
        idle(2);
        test_mode = 1'b1;
        bus_write(2'd1, 8'h10);
        test_mode = 1'b0;
        steps = 0;
        for (int i = 0; i < 20 && count[7:0] == 8'h10; i++) begin cyc(); steps++; end
        check("R6", "cycles to first step after load", steps, 5);

        // R4 wrap at div1
        bus_write(2'd3, 8'h00);
        test_mode = 1'b1;
        bus_write(2'd0, 8'hFF);
        bus_write(2'd1, 8'hFD);
        test_mode = 1'b0;
        ovf_zero_seen = 0;
        idle(6);
        check("R4", "overflow seen with zero count", int'(ovf_zero_seen), 1);

        // R9 wait without stop bit keeps counting
        wait_in = 1'b1;
        snap = count;
        idle(5);
        check("R9", "count moves in wait without stop bit", int'(count != snap), 1);
        bus_write(2'd2, 8'hC0);
        snap = count;
        idle(10);
        check("R9", "count held in wait", int'(count), int'(snap));
        check("R9", "stop indication", int'(acc_stop), 1);
        wait_in = 1'b0;
        idle(3);

        // R11 freeze
        bus_write(2'd2, 8'hA0);
        freeze_in = 1'b1;
        snap = count;
        idle(10);
        check("R11", "count held in freeze", int'(count), int'(snap));
        freeze_in = 1'b0;
        idle(4);
        check("R11", "count resumes after freeze", int'(count != snap), 1);

        // R10 precise locked at 0 after first write
        bus_write(2'd2, 8'h88);
        bus_read(2'd2, rb); check("R10", "precise stays 0", int'(rb), 8'h80);

        // R10 and R7 after a fresh reset
        do_reset();
        bus_write(2'd2, 8'h08);
        bus_read(2'd2, rb); check("R10", "first write sets precise", int'(rb), 8'h08);
        bus_write(2'd2, 8'hFF);
        bus_read(2'd2, rb); check("R7", "ctrl layout, low bits zero", int'(rb), 8'hF8);
        bus_write(2'd2, 8'h07);
        bus_read(2'd2, rb); check("R10", "precise kept, others cleared", int'(rb), 8'h08);
        idle(5);

        finish_run();
    end
endmodule